// File: doc/BRIEF.md
# Per-Line Input Noise Filter Bank

This block filters a bank of general-purpose input lines before they reach the pin-level status path. Each line first passes through a two-stage synchronizer. After that, each line has three possible treatments:

- **Bypass:** the synchronized level goes straight to the output.
- **Glitch filter:** a short-pulse filter that runs on the system clock.
- **Debounce filter:** a slower filter that samples on a divided tick derived from a slow-clock enable pulse.

Software sets up the bank through a small write-only port. Four mask registers work as pairs: a 1 in a write sets or clears the matching per-line bit, and a 0 leaves that bit alone. A fifth register holds a shared divider value. The divided tick repeats every DIV+1 slow pulses, which is half of a divided slow-clock period of (DIV+1)*2 slow periods. For a wanted cutoff frequency f with a 32768 Hz slow clock, software writes DIV = 32768/(2*f) - 1.

Every filter runs all the time, whatever its line's mode. Changing a line's configuration therefore only changes which of the three results drives that output line.

Top module: `infilt_bank`

## Requirements
- R1: After reset, every line is in bypass with the glitch filter selected, DIV is 0, all filter state is low, and `pinLevel` is all zeros while `padIn` is low.
- R2: A line whose filter is off shows `padIn` on `pinLevel` after exactly two rising clock edges.
- R3: A write to address 0 turns the filter on for each line whose `wrData` bit is 1. A write to address 1 turns it off for each such line. Lines whose bit is 0 keep their setting.
- R4: A write to address 2 selects debounce for each line whose bit is 1. A write to address 3 selects glitch for each such line. Lines whose bit is 0 keep their selection.
- R5: A glitch-filtered line changes only when the new level is seen on two consecutive synchronized samples. A sustained pad change appears after four rising edges, and a one-cycle pad pulse never appears.
- R6: A write to address 4 loads DIV from `wrData[13:0]`. The divided tick then fires on every (DIV+1)th `slowTick` pulse.
- R7: A debounce-filtered line samples only on divided ticks and changes only when two consecutive ticks agree on the new level. A pad pulse that spans fewer than DIV+1 slow pulses never appears.
- R8: A write to the divider register restarts the divider count, so the next tick comes on the (DIV+1)th slow pulse after the write. No tick is produced in the cycle of the write.
- R9: Filters keep running regardless of mode, so after any mix of configuration writes, each output equals the current result of the filter its line selects.
- R10: A write to addresses 5 to 7 has no effect on any line's configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | One-cycle enable marking each slow-clock period |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | 3 | Configuration register select |
| wrData | input | 32 | Write mask or divider value |
| padIn | input | 32 | Raw asynchronous line levels |
| pinLevel | output | 32 | Filtered line levels |

## Verification
The latency of each path is fixed:

- **Bypass:** a bypassed line answers two edges after a pad change.
- **Glitch:** a glitch-filtered line answers four edges after the change.
- **Debounce:** a debounce-filtered line answers two edges of synchronization plus two divided ticks.
- **Configuration:** a configuration write takes effect on the edge that captures it.

Inputs change on the falling edge, and the directed checks count falling edges from the stimulus to land on the exact cycle each result is due. The divider-restart case is timed to the edge: the output must still be high one cycle before its second post-write tick and low right after it. A cycle-level reference built from the requirements compares all 32 outputs at every falling edge during a long random mix of pad activity, slow pulses and writes, including writes to unused addresses.

// File: rtl/infilt_pkg.sv
package infilt_pkg;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_FILT_ON  = 3'd0,
    ADR_FILT_OFF = 3'd1,
    ADR_DEB_SEL  = 3'd2,
    ADR_GLT_SEL  = 3'd3,
    ADR_DIVIDER  = 3'd4
  } regSel_e;

  // Single-cycle strobes from control to datapath
  typedef struct packed {
    logic enSet;
    logic enClr;
    logic debSet;
    logic debClr;
    logic debTick;
  } ctlStrobe_t;

endpackage

// File: rtl/infilt_ctrl.sv
module infilt_ctrl
  import infilt_pkg::*;
#(
  parameter int unsigned PINS  = 32,
  parameter int unsigned DIV_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slowTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PINS-1:0]   wrData,
  output ctlStrobe_t        strobe,
  output logic [PINS-1:0]   wrMask
);

  localparam int unsigned DIV_LSB_W = (DIV_W < PINS) ? DIV_W : PINS;

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] divCnt;
  logic             divLoad;
  logic             tickNow;

  assign wrMask  = wrData;
  assign divLoad = wrEn && (wrAddr == ADR_DIVIDER);
  assign tickNow = slowTick && !divLoad && (divCnt == divReg);

  // Write decode into strobes
  always_comb begin
    strobe = '0;
    strobe.debTick = tickNow;
    if (wrEn) begin
      case (wrAddr)
        ADR_FILT_ON:  strobe.enSet  = 1'b1;
        ADR_FILT_OFF: strobe.enClr  = 1'b1;
        ADR_DEB_SEL:  strobe.debSet = 1'b1;
        ADR_GLT_SEL:  strobe.debClr = 1'b1;
        default:      ;
      endcase
    end
  end

  // Divider value register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divReg <= '0;
    end else if (divLoad) begin
      divReg <= DIV_W'(wrData[DIV_LSB_W-1:0]);
    end
  end

  // Slow-pulse counter; restarts on every divider write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
    end else if (divLoad) begin
      divCnt <= '0;
    end else if (slowTick) begin
      if (divCnt == divReg) divCnt <= '0;
      else                  divCnt <= divCnt + 1'b1;
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    divCnt <= divReg);

  // R6
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.debTick && divReg != '0) |=> !strobe.debTick);

  // R8
  div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    divLoad |=> (divCnt == '0));

  // R8
  no_tick_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    divLoad |-> !strobe.debTick);

endmodule

// File: rtl/infilt_lane.sv
module infilt_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic padRaw,
  input  logic filtOn,
  input  logic debSel,
  input  logic debTick,
  output logic level
);

  logic syncA, syncB;
  logic gPrev, gOut;
  logic dPrev, dOut;

  // Two-flop synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= padRaw;
      syncB <= syncA;
    end
  end

  // Glitch filter: needs two agreeing system-clock samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gPrev <= 1'b0;
      gOut  <= 1'b0;
    end else begin
      gPrev <= syncB;
      if (syncB == gPrev) gOut <= syncB;
    end
  end

  // Debounce filter: needs two agreeing divided-tick samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dPrev <= 1'b0;
      dOut  <= 1'b0;
    end else if (debTick) begin
      dPrev <= syncB;
      if (syncB == dPrev) dOut <= syncB;
    end
  end

  always_comb begin
    if (!filtOn)     level = syncB;
    else if (debSel) level = dOut;
    else             level = gOut;
  end

  // R5
  glitch_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gOut != $past(gOut)) |-> ($past(syncB) == $past(syncB, 2)));

  // R7
  deb_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !debTick |=> $stable(dOut));

endmodule

// File: rtl/infilt_datapath.sv
module infilt_datapath
  import infilt_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] padIn,
  input  ctlStrobe_t      strobe,
  input  logic [PINS-1:0] wrMask,
  output logic [PINS-1:0] pinLevel
);

  logic [PINS-1:0] filtOn;
  logic [PINS-1:0] debSel;

  // Per-line configuration, mask-based set/clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filtOn <= '0;
      debSel <= '0;
    end else begin
      if (strobe.enSet)  filtOn <= filtOn | wrMask;
      if (strobe.enClr)  filtOn <= filtOn & ~wrMask;
      if (strobe.debSet) debSel <= debSel | wrMask;
      if (strobe.debClr) debSel <= debSel & ~wrMask;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : gLane
    infilt_lane lane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .padRaw (padIn[i]),
      .filtOn (filtOn[i]),
      .debSel (debSel[i]),
      .debTick(strobe.debTick),
      .level  (pinLevel[i])
    );
  end

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.enSet |=> ((filtOn & $past(wrMask)) == $past(wrMask)));

  // R3
  en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.enClr |=> ((filtOn & ~$past(wrMask)) == ($past(filtOn) & ~$past(wrMask))));

  // R4
  sel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.debClr |=> ((debSel & $past(wrMask)) == '0));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.enSet || strobe.enClr || strobe.debSet || strobe.debClr)
      |=> ($stable(filtOn) && $stable(debSel)));

endmodule

// File: rtl/infilt_bank.sv
module infilt_bank
  import infilt_pkg::*;
#(
  parameter int unsigned PINS  = 32,
  parameter int unsigned DIV_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slowTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PINS-1:0]   wrData,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   pinLevel
);

  ctlStrobe_t      strobe;
  logic [PINS-1:0] wrMask;

  infilt_ctrl #(.PINS(PINS), .DIV_W(DIV_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .slowTick(slowTick),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strobe  (strobe),
    .wrMask  (wrMask)
  );

  infilt_datapath #(.PINS(PINS)) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .padIn   (padIn),
    .strobe  (strobe),
    .wrMask  (wrMask),
    .pinLevel(pinLevel)
  );

endmodule

// File: tb/infilt_bank_tb.sv
module infilt_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PINS  = 32;
  localparam int DIV_W = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            slowTick = 1'b0;
  logic            wrEn = 1'b0;
  logic [2:0]      wrAddr = '0;
  logic [PINS-1:0] wrData = '0;
  logic [PINS-1:0] padIn = '0;
  logic [PINS-1:0] pinLevel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  infilt_bank #(.PINS(PINS), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .slowTick(slowTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .padIn(padIn), .pinLevel(pinLevel)
  );

  // Reference model built from the requirements
  logic [PINS-1:0]  mSyncA, mSyncB, mGPrev, mGOut, mDPrev, mDOut, mEn, mDeb;
  logic [DIV_W-1:0] mDiv, mCnt;
  logic             mDivWr, mTick;

  assign mDivWr = wrEn && (wrAddr == 3'd4);
  assign mTick  = slowTick && !mDivWr && (mCnt == mDiv);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mSyncA <= '0; mSyncB <= '0; mGPrev <= '0; mGOut <= '0;
      mDPrev <= '0; mDOut <= '0; mEn <= '0; mDeb <= '0;
      mDiv <= '0; mCnt <= '0;
    end else begin
      mSyncA <= padIn;
      mSyncB <= mSyncA;
      mGPrev <= mSyncB;
      for (int i = 0; i < PINS; i++) begin
        if (mSyncB[i] == mGPrev[i]) mGOut[i] <= mSyncB[i];
        if (mTick && mSyncB[i] == mDPrev[i]) mDOut[i] <= mSyncB[i];
      end
      if (mTick) mDPrev <= mSyncB;
      if (mDivWr) mCnt <= '0;
      else if (slowTick) mCnt <= (mCnt == mDiv) ? '0 : mCnt + 1'b1;
      if (wrEn) begin
        case (wrAddr)
          3'd0: mEn  <= mEn | wrData;
          3'd1: mEn  <= mEn & ~wrData;
          3'd2: mDeb <= mDeb | wrData;
          3'd3: mDeb <= mDeb & ~wrData;
          3'd4: mDiv <= wrData[DIV_W-1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [PINS-1:0] expLevel();
    return (~mEn & mSyncB) | (mEn & ~mDeb & mGOut) | (mEn & mDeb & mDOut);
  endfunction

  task automatic check(input bit ok, input string req, input logic [PINS-1:0] act,
                       input logic [PINS-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R9: whole-bank comparison against the model at every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) check(pinLevel === expLevel(), "R9 model compare", pinLevel, expLevel());
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [PINS-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic checkBit(input int b, input logic v, input string req);
    check(pinLevel[b] === v, req, {31'b0, pinLevel[b]}, {31'b0, v});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    step(3);
    rst_n = 1'b1;
    step(1);
    check(pinLevel === '0, "R1 reset outputs low", pinLevel, '0);

    // R2 bypass latency
    padIn[0] = 1'b1;
    step(1); checkBit(0, 1'b0, "R2 one edge");
    step(1); checkBit(0, 1'b1, "R2 two edges");

    // R3 enable line 1 (glitch), R5 pulse rejection
    regWrite(3'd0, 32'h2);
    padIn[1] = 1'b1; step(1); padIn[1] = 1'b0;
    for (int k = 0; k < 6; k++) begin
      step(1); checkBit(1, 1'b0, "R5 one-cycle pulse dropped");
    end
    checkBit(0, 1'b1, "R3 zero bit keeps line 0 bypassed");
    padIn[1] = 1'b1;
    step(3); checkBit(1, 1'b0, "R5 three edges");
    step(1); checkBit(1, 1'b1, "R5 four edges");

    // R3 disable -> bypass
    regWrite(3'd1, 32'h2);
    padIn[1] = 1'b0;
    step(2); checkBit(1, 1'b0, "R3 disabled line bypassed");

    // R6/R7 debounce on line 2
    regWrite(3'd4, 32'd1);
    regWrite(3'd2, 32'h4);
    regWrite(3'd0, 32'h4);
    slowTick = 1'b1;
    step(6);
    padIn[2] = 1'b1; step(1); padIn[2] = 1'b0;
    for (int k = 0; k < 10; k++) begin
      step(1); checkBit(2, 1'b0, "R7 short pulse dropped");
    end
    padIn[2] = 1'b1;
    step(2); checkBit(2, 1'b0, "R7 not bypassed");
    step(8); checkBit(2, 1'b1, "R6 debounced level passes");

    // R8 divider restart timing with DIV=3
    step(4);
    wrEn = 1'b1; wrAddr = 3'd4; wrData = 32'd3; padIn[2] = 1'b0;
    step(1);
    wrEn = 1'b0; wrData = '0;
    step(6);
    step(1); checkBit(2, 1'b1, "R8 before second tick");
    step(1); checkBit(2, 1'b0, "R8 at second tick");

    // R4 back to glitch
    regWrite(3'd3, 32'h4);
    padIn[2] = 1'b1;
    step(3); checkBit(2, 1'b0, "R4 glitch three edges");
    step(1); checkBit(2, 1'b1, "R4 glitch four edges");

    // R10 unused addresses
    regWrite(3'd5, '1);
    regWrite(3'd6, '1);
    regWrite(3'd7, '1);
    padIn[3] = 1'b1;
    step(2); checkBit(3, 1'b1, "R10 line 3 still bypassed");
    padIn[2] = 1'b0;
    step(3); checkBit(2, 1'b1, "R10 line 2 still glitch");

    // R9 random mix
    for (int c = 0; c < 5000; c++) begin
      slowTick = ($urandom % 3) != 0;
      for (int b = 0; b < PINS; b++)
        if (($urandom % 8) == 0) padIn[b] = ~padIn[b];
      if (($urandom % 40) == 0) begin
        wrEn = 1'b1;
        wrAddr = 3'($urandom % 8);
        wrData = (wrAddr == 3'd4) ? 32'($urandom % 4) : $urandom;
      end else begin
        wrEn = 1'b0;
      end
      step(1);
    end
    wrEn = 1'b0;
    step(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule